// File: doc/BRIEF.md
# Compare-Output Waveform Timer

A 16-bit up/down counter advances on a clock-enable pulse from a free-running prescaler. The prescaler is selected from the system clock. The block supports three waveform modes:

- **Clear-on-compare:** the count wraps from the programmed TOP to zero. Compare values take effect at once.
- **Fast PWM:** the count also wraps from TOP to zero. New compare values wait in a buffer until the TOP step.
- **Phase-correct PWM:** the count climbs to TOP, then falls back to zero. Compare values are buffered as in fast PWM.

Each compare channel holds an active compare value and a pending buffer. It drives a waveform register according to a 2-bit output-action field, and it sets a sticky match flag whenever the count equals its active value on an enabled step. A sticky overflow flag marks the end of each period.

Software-side logic writes the compare values, the TOP value and the flag-clear word through a single-cycle write port. The waveform reaches an output pin only when the channel's action field is nonzero and its pin-direction bit is set. With the default parameters the block has two channels.

Top module: `cmp_wave_timer`

## Requirements
- R1: The counter changes only on enabled steps. The clock-select code selects the step rate:
  - 0, 6 and 7 stop the counter.
  - 1 steps every cycle.
  - 2, 3, 4 and 5 step once per 8, 64, 256 and 1024 cycles respectively.
  - A step falls on the cycle where a cycle counter, cleared by reset and wrapping at 1024, has all of its low 3, 6, 8 or 10 bits set.
- R2: In waveform mode 0 (clear-on-compare) and mode 1 (fast PWM), a step taken with the count equal to TOP loads zero. Any other step adds one, wrapping at 16 bits.
- R3: In waveform modes 2 and 3 (phase-correct), the counter counts up until a step taken at a count of TOP or above. It then counts down to zero, and from zero it counts up again.
- R4: The overflow flag is set by a step taken at count TOP in modes 0 and 1, and by a step taken at count zero in modes 2 and 3.
- R5: A write to compare address i updates channel i's buffer.
  - In mode 0 the write also updates the active compare value in the same cycle.
  - In modes 1 to 3 the active value is loaded from the buffer only on a step taken at count TOP. The old value applies until then.
- R6: A step taken with the count equal to a channel's active value sets that channel's match flag in the same cycle as its output action. In mode 0 the action field does the following:
  - 00: no action.
  - 01: toggle the waveform.
  - 10: drive the waveform low.
  - 11: drive the waveform high.
- R7: In fast PWM the action field works as follows:
  - 10 drives the waveform low on match and high on the TOP step.
  - 11 does the reverse.
  - The TOP action takes precedence over a match in the same step.
  - 01 toggles on match.
- R8: In phase-correct modes the action field works as follows:
  - 10 drives the waveform low on a match while counting up and high on a match while counting down.
  - 11 does the reverse.
  - 01 toggles on match.
- R9: Each channel's output enable is high when its action field is nonzero and its pin-direction bit is set. When the output enable is low, the waveform output reads 0.
- R10: A write to address NCH+1 clears each flag whose data bit is one: bit 0 is overflow and bit 1+i is the match flag of channel i. A set condition in the same cycle wins over the clear. While the clock select is a stop code, flags neither set nor clear.
- R11: The write address map is as follows:
  - Address i (below NCH) is compare channel i.
  - Address NCH is TOP.
  - After reset the count, compare values, waveforms and flags are zero, TOP is all ones, and the counter faces upward.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wmode | input | 2 | Waveform mode: 0 clear-on-compare, 1 fast PWM, 2/3 phase-correct |
| clk_sel | input | 3 | Prescaler select code |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | AW (2) | Register write address |
| wr_data | input | W (16) | Register write data |
| out_mode | input | 2*NCH (4) | Per-channel 2-bit output action, channel i in bits [2i+1:2i] |
| pin_dir | input | NCH (2) | Per-channel pin direction enable |
| count | output | W (16) | Current count value |
| wave_out | output | NCH (2) | Gated waveform outputs |
| wave_oe | output | NCH (2) | Waveform output enables |
| ovf_flag | output | 1 | Sticky overflow flag |
| match_flag | output | NCH (2) | Sticky per-channel compare-match flags |

## Verification
Two pairs of functions can land in the same cycle, and the bench provokes both.

The first pair is the flag-clear write and a flag-set step. The bench runs a short period at divide-by-1 while writing the clear word on every cycle, so that overflow and match steps are sure to meet a clear. A behavioural model then judges the sticky flags cycle by cycle, with the set taking priority.

The second pair is the TOP step and a compare-buffer write or a compare match at TOP:
- In fast PWM, a channel's compare value equals TOP.
- A new compare value is written in the middle of a period.

The model checks that the old value stays active until the TOP step and that the TOP output action wins.

// File: rtl/cwt_pkg.sv
package cwt_pkg;

   typedef enum logic [1:0] {
      WM_CLR_ON_CMP = 2'd0,
      WM_FAST_PWM   = 2'd1,
      WM_PHASE_A    = 2'd2,
      WM_PHASE_B    = 2'd3
   } wmode_e;

   localparam logic [2:0] CS_STOP  = 3'd0;
   localparam logic [2:0] CS_DIV1  = 3'd1;
   localparam logic [2:0] CS_DIV8  = 3'd2;
   localparam logic [2:0] CS_DIV64 = 3'd3;
   localparam logic [2:0] CS_DIV256 = 3'd4;
   localparam logic [2:0] CS_DIV1K = 3'd5;

   localparam logic [1:0] OA_NONE   = 2'b00;
   localparam logic [1:0] OA_TOGGLE = 2'b01;
   localparam logic [1:0] OA_LOW    = 2'b10;
   localparam logic [1:0] OA_HIGH   = 2'b11;

   function automatic logic is_phase(input logic [1:0] m);
      return m[1];
   endfunction

   function automatic logic is_buffered(input logic [1:0] m);
      return m != WM_CLR_ON_CMP;
   endfunction

   // number of low prescaler bits that must be all ones for a divided tap
   function automatic int tap_bits(input int k);
      case (k)
         0: return 3;
         1: return 6;
         2: return 8;
         default: return 10;
      endcase
   endfunction

endpackage

// File: rtl/cwt_prescale.sv
module cwt_prescale
   import cwt_pkg::*;
#(
   parameter int PW = 10
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic [2:0] sel,
   output logic       tick,
   output logic       stopped
);

   localparam int NDIV = 4;

   generate
      if (PW < 10) begin : g_bad_width
         $error("cwt_prescale: PW must be at least 10");
      end
   endgenerate

   logic [PW-1:0]   pre_q;
   logic [NDIV-1:0] tap;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pre_q <= '0;
      else        pre_q <= pre_q + 1'b1;
   end

   generate
      for (genvar k = 0; k < NDIV; k++) begin : g_tap
         assign tap[k] = &pre_q[tap_bits(k)-1:0];
      end
   endgenerate

   always_comb begin
      case (sel)
         CS_DIV1:   tick = 1'b1;
         CS_DIV8:   tick = tap[0];
         CS_DIV64:  tick = tap[1];
         CS_DIV256: tick = tap[2];
         CS_DIV1K:  tick = tap[3];
         default:   tick = 1'b0;
      endcase
   end

   assign stopped = (sel == CS_STOP) || (sel > CS_DIV1K);

   a_r1_div1_every_cycle: assert property (@(posedge clk) disable iff (!rst_n)
      (sel == CS_DIV1) |-> tick);
   a_r1_stop_no_step: assert property (@(posedge clk) disable iff (!rst_n)
      stopped |-> !tick);
   a_r1_div8_spacing: assert property (@(posedge clk) disable iff (!rst_n)
      (sel == CS_DIV8 && $past(sel) == CS_DIV8 && tick) |=> !tick);

endmodule

// File: rtl/cwt_counter.sv
module cwt_counter
   import cwt_pkg::*;
#(
   parameter int W = 16
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         tick,
   input  logic [1:0]   wmode,
   input  logic [W-1:0] top,
   output logic [W-1:0] cnt,
   output logic         at_top,
   output logic         dir_up
);

   localparam logic [W-1:0] ZERO = '0;
   localparam logic [W-1:0] ONE  = W'(1);

   logic [W-1:0] cnt_q;
   logic         up_q;

   assign cnt    = cnt_q;
   assign at_top = (cnt_q == top);
   assign dir_up = up_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= ZERO;
         up_q  <= 1'b1;
      end else if (tick) begin
         if (!is_phase(wmode)) begin
            up_q  <= 1'b1;
            cnt_q <= at_top ? ZERO : cnt_q + ONE;
         end else if (up_q) begin
            if (cnt_q >= top) begin
               up_q  <= 1'b0;
               cnt_q <= (cnt_q == ZERO) ? ZERO : cnt_q - ONE;
            end else begin
               cnt_q <= cnt_q + ONE;
            end
         end else begin
            if (cnt_q == ZERO) begin
               up_q  <= 1'b1;
               cnt_q <= (top == ZERO) ? ZERO : ONE;
            end else begin
               cnt_q <= cnt_q - ONE;
            end
         end
      end
   end

   a_r1_frozen_without_step: assert property (@(posedge clk) disable iff (!rst_n)
      !tick |=> $stable(cnt));
   a_r2_wrap_to_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && !is_phase(wmode) && cnt == top) |=> (cnt == ZERO));
   a_r3_turn_down_at_top: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && is_phase(wmode) && dir_up && cnt >= top && top != ZERO) |=> !dir_up);
   a_r3_turn_up_at_bottom: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && is_phase(wmode) && !dir_up && cnt == ZERO) |=> dir_up);

endmodule

// File: rtl/cwt_channel.sv
module cwt_channel
   import cwt_pkg::*;
#(
   parameter int W = 16
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         tick,
   input  logic [1:0]   wmode,
   input  logic [W-1:0] cnt,
   input  logic         at_top,
   input  logic         dir_up,
   input  logic         wr_cmp,
   input  logic [W-1:0] wr_data,
   input  logic [1:0]   action,
   output logic         wave,
   output logic         hit
);

   logic [W-1:0] active_q;
   logic [W-1:0] pend_q;
   logic         wave_q;
   logic         wave_d;
   logic         top_step;

   assign hit      = tick && (cnt == active_q);
   assign top_step = tick && at_top;
   assign wave     = wave_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pend_q   <= '0;
         active_q <= '0;
      end else begin
         if (wr_cmp) pend_q <= wr_data;
         if (!is_buffered(wmode)) begin
            if (wr_cmp) active_q <= wr_data;
         end else if (top_step) begin
            active_q <= pend_q;
         end
      end
   end

   always_comb begin
      wave_d = wave_q;
      if (tick) begin
         case (wmode)
            WM_CLR_ON_CMP: begin
               if (hit) begin
                  case (action)
                     OA_TOGGLE: wave_d = ~wave_q;
                     OA_LOW:    wave_d = 1'b0;
                     OA_HIGH:   wave_d = 1'b1;
                     default:   wave_d = wave_q;
                  endcase
               end
            end
            WM_FAST_PWM: begin
               if (action == OA_TOGGLE) begin
                  if (hit) wave_d = ~wave_q;
               end else if (action != OA_NONE) begin
                  if (at_top)   wave_d = (action == OA_LOW);
                  else if (hit) wave_d = (action == OA_HIGH);
               end
            end
            default: begin
               if (hit) begin
                  case (action)
                     OA_TOGGLE: wave_d = ~wave_q;
                     OA_LOW:    wave_d = ~dir_up;
                     OA_HIGH:   wave_d = dir_up;
                     default:   wave_d = wave_q;
                  endcase
               end
            end
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) wave_q <= 1'b0;
      else        wave_q <= wave_d;
   end

   a_r5_direct_load: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_cmp && !is_buffered(wmode)) |=> (active_q == $past(wr_data)));
   a_r5_hold_until_top: assert property (@(posedge clk) disable iff (!rst_n)
      (is_buffered(wmode) && !top_step) |=> $stable(active_q));
   a_r6_toggle_on_match: assert property (@(posedge clk) disable iff (!rst_n)
      (hit && wmode == WM_CLR_ON_CMP && action == OA_TOGGLE) |=> (wave != $past(wave)));
   a_r7_top_sets_high: assert property (@(posedge clk) disable iff (!rst_n)
      (top_step && wmode == WM_FAST_PWM && action == OA_LOW) |=> wave);

endmodule

// File: rtl/cmp_wave_timer.sv
module cmp_wave_timer
   import cwt_pkg::*;
#(
   parameter int W   = 16,
   parameter int NCH = 2,
   parameter int PW  = 10,
   parameter int AW  = $clog2(NCH + 2)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [1:0]        wmode,
   input  logic [2:0]        clk_sel,
   input  logic              wr_en,
   input  logic [AW-1:0]     wr_addr,
   input  logic [W-1:0]      wr_data,
   input  logic [2*NCH-1:0]  out_mode,
   input  logic [NCH-1:0]    pin_dir,
   output logic [W-1:0]      count,
   output logic [NCH-1:0]    wave_out,
   output logic [NCH-1:0]    wave_oe,
   output logic              ovf_flag,
   output logic [NCH-1:0]    match_flag
);

   localparam logic [AW-1:0] ADDR_TOP   = AW'(NCH);
   localparam logic [AW-1:0] ADDR_FLAGS = AW'(NCH + 1);

   generate
      if (NCH < 1 || NCH > 4) begin : g_bad_nch
         $error("cmp_wave_timer: NCH must be 1..4");
      end
      if (W < NCH + 1 || W < 2) begin : g_bad_w
         $error("cmp_wave_timer: W too narrow for the flag word");
      end
      if (AW < $clog2(NCH + 2)) begin : g_bad_aw
         $error("cmp_wave_timer: AW too narrow for the address map");
      end
   endgenerate

   logic           tick;
   logic           stopped;
   logic [W-1:0]   top_q;
   logic [W-1:0]   cnt;
   logic           at_top;
   logic           dir_up;
   logic [NCH-1:0] hit;
   logic [NCH-1:0] wave;
   logic           ovf_set;
   logic           clr_ok;
   logic           ovf_q;
   logic [NCH-1:0] mflag_q;

   cwt_prescale #(.PW(PW)) u_pre (
      .clk     (clk),
      .rst_n   (rst_n),
      .sel     (clk_sel),
      .tick    (tick),
      .stopped (stopped)
   );

   cwt_counter #(.W(W)) u_cnt (
      .clk    (clk),
      .rst_n  (rst_n),
      .tick   (tick),
      .wmode  (wmode),
      .top    (top_q),
      .cnt    (cnt),
      .at_top (at_top),
      .dir_up (dir_up)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                          top_q <= '1;
      else if (wr_en && wr_addr == ADDR_TOP) top_q <= wr_data;
   end

   generate
      for (genvar i = 0; i < NCH; i++) begin : g_ch
         logic [1:0] act;
         assign act = out_mode[2*i +: 2];

         cwt_channel #(.W(W)) u_ch (
            .clk     (clk),
            .rst_n   (rst_n),
            .tick    (tick),
            .wmode   (wmode),
            .cnt     (cnt),
            .at_top  (at_top),
            .dir_up  (dir_up),
            .wr_cmp  (wr_en && wr_addr == AW'(i)),
            .wr_data (wr_data),
            .action  (act),
            .wave    (wave[i]),
            .hit     (hit[i])
         );

         assign wave_oe[i]  = (act != OA_NONE) && pin_dir[i];
         assign wave_out[i] = wave_oe[i] & wave[i];

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) mflag_q[i] <= 1'b0;
            else        mflag_q[i] <= hit[i] | (mflag_q[i] & ~(clr_ok & wr_data[1+i]));
         end
      end
   endgenerate

   assign ovf_set = tick && (is_phase(wmode) ? (cnt == '0) : at_top);
   assign clr_ok  = wr_en && (wr_addr == ADDR_FLAGS) && !stopped;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) ovf_q <= 1'b0;
      else        ovf_q <= ovf_set | (ovf_q & ~(clr_ok & wr_data[0]));
   end

   assign count      = cnt;
   assign ovf_flag   = ovf_q;
   assign match_flag = mflag_q;

   a_r10_stop_freezes_flags: assert property (@(posedge clk) disable iff (!rst_n)
      stopped |=> ($stable(ovf_flag) && $stable(match_flag)));
   a_r10_set_beats_clear: assert property (@(posedge clk) disable iff (!rst_n)
      ovf_set |=> ovf_flag);
   a_r4_ovf_only_on_step: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ovf_flag) |-> $past(tick));
   a_r9_no_drive_when_off: assert property (@(posedge clk) disable iff (!rst_n)
      (pin_dir == '0) |-> (wave_oe == '0));

endmodule

// File: tb/cmp_wave_timer_tb_top.sv
module cmp_wave_timer_tb_top;

   localparam int W = 16;
   localparam int NCH = 2;
   localparam int AW = 2;

   logic           clk = 1'b0;
   logic           rst_n = 1'b0;
   logic [1:0]     wmode = 2'd0;
   logic [2:0]     clk_sel = 3'd0;
   logic           wr_en = 1'b0;
   logic [AW-1:0]  wr_addr = '0;
   logic [W-1:0]   wr_data = '0;
   logic [3:0]     out_mode = '0;
   logic [1:0]     pin_dir = '0;
   logic [W-1:0]   count;
   logic [1:0]     wave_out;
   logic [1:0]     wave_oe;
   logic           ovf_flag;
   logic [1:0]     match_flag;

   int errors = 0;
   int checks = 0;
   bit done = 0;
   string cur_req = "R11";

   always #10 clk = ~clk;

   cmp_wave_timer dut_i (
      .clk(clk), .rst_n(rst_n), .wmode(wmode), .clk_sel(clk_sel),
      .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
      .out_mode(out_mode), .pin_dir(pin_dir), .count(count),
      .wave_out(wave_out), .wave_oe(wave_oe), .ovf_flag(ovf_flag),
      .match_flag(match_flag)
   );

   // behavioural reference state
   int m_pre = 0;
   int m_cnt = 0;
   int m_top = 65535;
   int m_act[2] = '{0, 0};
   int m_buf[2] = '{0, 0};
   bit m_up = 1;
   bit m_wave[2] = '{0, 0};
   bit m_ovf = 0;
   bit m_mf[2] = '{0, 0};

   function automatic bit step_now(int pre, int sel);
      case (sel)
         1: return 1;
         2: return (pre % 8) == 7;
         3: return (pre % 64) == 63;
         4: return (pre % 256) == 255;
         5: return (pre % 1024) == 1023;
         default: return 0;
      endcase
   endfunction

   always @(posedge clk) begin
      if (!rst_n) begin
         m_pre = 0; m_cnt = 0; m_top = 65535; m_up = 1; m_ovf = 0;
         for (int i = 0; i < 2; i++) begin
            m_act[i] = 0; m_buf[i] = 0; m_wave[i] = 0; m_mf[i] = 0;
         end
      end else begin
         bit tk, stop, ph, attop, clr;
         bit hit[2];
         tk    = step_now(m_pre, clk_sel);
         stop  = !(clk_sel >= 1 && clk_sel <= 5);
         ph    = wmode >= 2;
         attop = (m_cnt == m_top);
         clr   = wr_en && wr_addr == 3 && !stop;
         for (int i = 0; i < 2; i++) begin
            int a;
            a = out_mode[2*i +: 2];
            hit[i] = tk && (m_cnt == m_act[i]);
            if (tk) begin
               if (wmode == 0) begin
                  if (hit[i]) begin
                     if (a == 1) m_wave[i] = !m_wave[i];
                     else if (a == 2) m_wave[i] = 0;
                     else if (a == 3) m_wave[i] = 1;
                  end
               end else if (wmode == 1) begin
                  if (a == 1) begin
                     if (hit[i]) m_wave[i] = !m_wave[i];
                  end else if (a != 0) begin
                     if (attop) m_wave[i] = (a == 2);
                     else if (hit[i]) m_wave[i] = (a == 3);
                  end
               end else begin
                  if (hit[i]) begin
                     if (a == 1) m_wave[i] = !m_wave[i];
                     else if (a == 2) m_wave[i] = !m_up;
                     else if (a == 3) m_wave[i] = m_up;
                  end
               end
            end
            m_mf[i] = hit[i] || (m_mf[i] && !(clr && wr_data[1+i]));
            if (wmode != 0 && tk && attop) m_act[i] = m_buf[i];
            if (wr_en && wr_addr == i) begin
               m_buf[i] = wr_data;
               if (wmode == 0) m_act[i] = wr_data;
            end
         end
         m_ovf = (tk && (ph ? (m_cnt == 0) : attop)) || (m_ovf && !(clr && wr_data[0]));
         if (tk) begin
            if (!ph) begin
               m_up = 1;
               m_cnt = attop ? 0 : (m_cnt + 1) % 65536;
            end else if (m_up) begin
               if (m_cnt >= m_top) begin
                  m_up = 0;
                  m_cnt = (m_cnt == 0) ? 0 : m_cnt - 1;
               end else m_cnt = m_cnt + 1;
            end else begin
               if (m_cnt == 0) begin
                  m_up = 1;
                  m_cnt = (m_top == 0) ? 0 : 1;
               end else m_cnt = m_cnt - 1;
            end
         end
         if (wr_en && wr_addr == 2) m_top = wr_data;
         m_pre = (m_pre + 1) % 1024;
      end
   end

   task automatic check(string req, string what, int act, int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s %s actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
      end
   endtask

   // compare every cycle, away from the edge and after input changes
   always @(negedge clk) begin
      #5;
      if (!done) begin
         for (int i = 0; i < 2; i++) begin
            bit oe;
            oe = (out_mode[2*i +: 2] != 0) && pin_dir[i];
            check(cur_req, "wave_oe", wave_oe[i], oe);
            check(cur_req, "wave_out", wave_out[i], oe && m_wave[i]);
            check(cur_req, "match_flag", match_flag[i], m_mf[i]);
         end
         check(cur_req, "count", count, m_cnt);
         check(cur_req, "ovf_flag", ovf_flag, m_ovf);
      end
   end

   task automatic run(int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic wr(int addr, int data);
      @(negedge clk);
      wr_en = 1; wr_addr = AW'(addr); wr_data = W'(data);
      @(negedge clk);
      wr_en = 0;
   endtask

   task automatic finish_run();
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   endtask

   initial begin
      #3000000;
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      finish_run();
   end

   initial begin
      run(3);
      // R11: reset state
      check("R11", "reset count", count, 0);
      check("R11", "reset ovf", ovf_flag, 0);
      check("R11", "reset match", match_flag, 0);
      check("R11", "reset wave", wave_out, 0);
      @(negedge clk) rst_n = 1;

      // R1 stop: nothing moves
      cur_req = "R1";
      run(20);
      check("R1", "stopped count", count, 0);

      // R2 / R6: clear-on-compare, divide by 1
      cur_req = "R2";
      wr(2, 9); wr(0, 3); wr(1, 7);
      out_mode = 4'b11_01; pin_dir = 2'b11;
      wmode = 0; clk_sel = 1;
      run(60);
      cur_req = "R6";
      out_mode = 4'b10_01;
      run(40);
      // R5 immediate load in mode 0
      cur_req = "R5";
      wr(0, 6);
      run(30);
      // R10: clear word every cycle, set/clear collisions
      cur_req = "R10";
      wr(2, 4);
      @(negedge clk);
      wr_en = 1; wr_addr = 3; wr_data = 16'h7;
      run(20);
      wr_en = 0;
      run(5);
      // R10: stop freezes flags, clear ignored
      clk_sel = 0;
      run(6);
      wr(3, 7);
      run(3);
      check("R10", "frozen ovf", ovf_flag, m_ovf);
      check("R10", "frozen match", match_flag, {m_mf[1], m_mf[0]});

      // R7 / R4 / R5: fast PWM, divide by 8, channel B compare at TOP
      cur_req = "R7";
      wmode = 1; clk_sel = 2;
      wr(2, 20); wr(0, 5); wr(1, 20);
      out_mode = 4'b11_10;
      run(400);
      cur_req = "R5";
      wr(0, 12);
      run(400);
      cur_req = "R4";
      wr(3, 7);
      run(200);

      // R3 / R8: phase-correct, divide by 1
      cur_req = "R3";
      wmode = 2; clk_sel = 1;
      wr(2, 15); wr(0, 4); wr(1, 10);
      out_mode = 4'b11_10;
      run(120);
      cur_req = "R8";
      out_mode = 4'b01_11;
      wmode = 3;
      run(100);

      // R9: pin enables and disconnected mode
      cur_req = "R9";
      pin_dir = 2'b01;
      run(30);
      out_mode = 4'b10_00;
      pin_dir = 2'b11;
      run(30);
      check("R9", "disconnected oe", wave_oe[0], 0);

      // R1: slower taps
      cur_req = "R1";
      wmode = 0; out_mode = 4'b01_01;
      wr(2, 3); wr(0, 1); wr(1, 2);
      clk_sel = 3; run(600);
      clk_sel = 4; run(1200);
      clk_sel = 5; run(5000);
      clk_sel = 7; run(50);

      finish_run();
   end

endmodule